// File: doc/BRIEF.md
# Protected Program Sequencer for a Serial Flash Array

This unit sits behind the serial command front end of a small flash memory. It owns the status register: the enable latch, a protection-enable bit, a two-bit block-lock level, and the program-in-progress flag. It decides whether each program request may go ahead. A program request carries a sector address and a full sector of data. A status write request carries one data byte. Permission comes from three things: the enable latch, a hardware protect pin that counts only while the protection-enable bit is set, and the block-lock level.

An accepted request starts a self-timed cycle of `PROG_CYCLES` clock cycles. During that cycle the unit reports busy and the status byte reads as all ones. For an array program, it emits one write strobe per byte of the captured sector to the array, in ascending address order. A status write commits its fields when it is accepted. When any cycle completes, the enable latch clears. The front end tells the unit when a status write sequence is being shifted in. A protect-pin assertion seen during that window cancels the write that follows.

Top module: `flash_guard`

## Requirements
- R1: After reset the status byte is 0x00. When idle, the status byte is {bit7 protect-enable, bits 6..4 zero, bits 3..2 lock level, bit1 enable latch, bit0 zero}.
- R2: While a cycle runs, `busy` is 1 and `status` reads 0xFF.
- R3: When idle, `latch_clr` clears the enable latch and `latch_set` sets it. If both pulse in the same cycle, the latch clears.
- R4: A program or status write request made while the enable latch is 0 starts nothing and changes no state.
- R5: An accepted status write stores data bit 7 as protect-enable and data bits 3..2 as the lock level. All other data bits are ignored.
- R6: Hardware protection is active when protect-enable is 1 and `prot_pin` is 0. A status write requested under hardware protection is refused, and this includes an attempt to clear protect-enable. When protect-enable is 0, `prot_pin` has no effect.
- R7: If hardware protection is active in any cycle while `sr_seq` is high, the status write requested at the end of that sequence is refused, even if the pin has gone high again.
- R8: A program request is refused silently when its address is locked. Lock level 00 locks nothing, 01 locks addresses whose two top bits are 11, 10 locks addresses whose top bit is 1, and 11 locks everything. A refused request keeps the enable latch set.
- R9: An accepted program holds `busy` for exactly PROG_CYCLES cycles. It gives exactly SECTOR_BYTES write strobes on consecutive cycles, with address {sector base, offset 0..SECTOR_BYTES-1}, where the offset bits of `pg_addr` are ignored. The byte at offset k comes from pg_data[8k+7:8k]. A status write gives no strobe.
- R10: When a cycle completes, `busy` falls and the enable latch reads 0.
- R11: While busy, requests, latch pulses and `prot_pin` changes have no effect on the running cycle or on the status that follows it.
- R12: A status write requested in the same cycle as a program request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_pin | input | 1 | Hardware protect pin; 0 protects when protect-enable is set |
| latch_set | input | 1 | Pulse: set the enable latch |
| latch_clr | input | 1 | Pulse: clear the enable latch |
| sr_seq | input | 1 | High while a status write sequence is being shifted in |
| sr_req | input | 1 | Pulse: status write request |
| sr_data | input | 8 | Status write data |
| pg_req | input | 1 | Pulse: sector program request |
| pg_addr | input | ADDR_W | Program address; the offset bits are ignored |
| pg_data | input | SECTOR_BYTES*8 | Sector data, byte k in bits 8k+7..8k |
| status | output | 8 | Status byte |
| busy | output | 1 | Self-timed cycle in progress |
| mem_we | output | 1 | Array byte write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The assertions check on every cycle that the status reads all ones while busy, that strobes occur only while busy and step through consecutive addresses, and that the latch is clear when a cycle ends. They also check that no cycle starts without the latch, under hardware protection for a status write, or on a fully locked array. Only the bench scenarios show that the exact cycle counts are right, that each lock level and each address boundary is right, that the written byte values are right, and that a pin glitch cancels a later status write. The scenarios also show that a refused request leaves the latch set and that disturbances during a busy cycle leave no trace.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int ST_PROT_EN = 7;
  localparam int ST_LVL_HI  = 3;
  localparam int ST_LVL_LO  = 2;
  localparam int ST_LATCH   = 1;
  localparam int ST_BUSY    = 0;

  typedef enum logic [1:0] {
    LVL_OPEN    = 2'b00,
    LVL_QUARTER = 2'b01,
    LVL_HALF    = 2'b10,
    LVL_FULL    = 2'b11
  } lock_lvl_e;

  typedef enum logic {
    JOB_STATUS = 1'b0,
    JOB_ARRAY  = 1'b1
  } job_e;
endpackage

// File: rtl/fg_range_lock.sv
module fg_range_lock
  import fg_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  lock_lvl_e         lvl,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  always_comb begin
    unique case (lvl)
      LVL_OPEN:    locked = 1'b0;
      LVL_QUARTER: locked = &addr[ADDR_W-1 -: 2];
      LVL_HALF:    locked = addr[ADDR_W-1];
      default:     locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/fg_grant.sv
module fg_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic latch_on,
  input  logic prot_en,
  input  logic prot_pin,
  input  logic lock_hit,
  input  logic sr_seq,
  input  logic sr_req,
  input  logic pg_req,
  output logic start_array,
  output logic start_status
);
  logic hw_prot;
  logic seq_q, seq_d;
  logic cancel_q, cancel_d;

  assign hw_prot = prot_en & ~prot_pin;

  always_comb begin
    seq_d    = sr_seq;
    cancel_d = cancel_q;
    if (sr_seq) begin
      cancel_d = seq_q ? (cancel_q | hw_prot) : hw_prot;
    end else if (sr_req) begin
      cancel_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q    <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      seq_q    <= seq_d;
      cancel_q <= cancel_d;
    end
  end

  assign start_array  = ~busy & pg_req & latch_on & ~lock_hit;
  assign start_status = ~busy & ~pg_req & sr_req & latch_on & ~hw_prot & ~cancel_q;
endmodule

// File: rtl/fg_cycle_timer.sv
module fg_cycle_timer #(
  parameter int PROG_CYCLES  = 40,
  parameter int SECTOR_BYTES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             idx_valid,
  output logic [OFS_W-1:0] idx
);
  localparam int OFS_W = $clog2(SECTOR_BYTES);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [OFS_W:0]   IDX_END  = (OFS_W + 1)'(SECTOR_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OFS_W:0]   widx_q, widx_d;
  logic             cnt_en;

  assign busy   = (cnt_q != '0);
  assign done   = (cnt_q == CNT_ONE);
  assign cnt_en = start | busy;

  always_comb begin
    cnt_d  = cnt_q;
    widx_d = widx_q;
    if (start) begin
      cnt_d  = CNT_LOAD;
      widx_d = '0;
    end else if (busy) begin
      cnt_d = cnt_q - CNT_ONE;
      if (widx_q != IDX_END) widx_d = widx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      widx_q <= '0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      widx_q <= widx_d;
    end
  end

  assign idx_valid = busy & (widx_q < IDX_END);
  assign idx       = widx_q[OFS_W-1:0];
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int SECTOR_BYTES = 32,
  parameter int PROG_CYCLES  = 40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      prot_pin,
  input  logic                      latch_set,
  input  logic                      latch_clr,
  input  logic                      sr_seq,
  input  logic                      sr_req,
  input  logic [7:0]                sr_data,
  input  logic                      pg_req,
  input  logic [ADDR_W-1:0]         pg_addr,
  input  logic [SECTOR_BYTES*8-1:0] pg_data,
  output logic [7:0]                status,
  output logic                      busy,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [7:0]                mem_wdata
);
  localparam int OFS_W  = $clog2(SECTOR_BYTES);
  localparam int BASE_W = ADDR_W - OFS_W;
  localparam int BUF_W  = SECTOR_BYTES * 8;

  logic              prot_en_q, prot_en_d;
  lock_lvl_e         lvl_q, lvl_d;
  logic              latch_q, latch_d;
  job_e              job_q, job_d;
  logic [BASE_W-1:0] base_q;
  logic [BUF_W-1:0]  buf_q;

  logic             lock_hit, start_array, start_status, start_any;
  logic             cyc_busy, cyc_done, idx_valid;
  logic [OFS_W-1:0] idx;
  logic [7:0]       sector_byte [SECTOR_BYTES];

  fg_range_lock #(.ADDR_W(ADDR_W)) u_lock (
    .lvl    (lvl_q),
    .addr   (pg_addr),
    .locked (lock_hit)
  );

  fg_grant u_grant (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (cyc_busy),
    .latch_on     (latch_q),
    .prot_en      (prot_en_q),
    .prot_pin     (prot_pin),
    .lock_hit     (lock_hit),
    .sr_seq       (sr_seq),
    .sr_req       (sr_req),
    .pg_req       (pg_req),
    .start_array  (start_array),
    .start_status (start_status)
  );

  assign start_any = start_array | start_status;

  fg_cycle_timer #(.PROG_CYCLES(PROG_CYCLES), .SECTOR_BYTES(SECTOR_BYTES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_any),
    .busy      (cyc_busy),
    .done      (cyc_done),
    .idx_valid (idx_valid),
    .idx       (idx)
  );

  // Next state of the status fields and the job kind.
  always_comb begin
    prot_en_d = prot_en_q;
    lvl_d     = lvl_q;
    latch_d   = latch_q;
    job_d     = job_q;
    if (start_array) job_d = JOB_ARRAY;
    if (start_status) begin
      job_d     = JOB_STATUS;
      prot_en_d = sr_data[ST_PROT_EN];
      lvl_d     = lock_lvl_e'(sr_data[ST_LVL_HI:ST_LVL_LO]);
    end
    if (cyc_busy) begin
      if (cyc_done) latch_d = 1'b0;
    end else if (latch_clr) begin
      latch_d = 1'b0;
    end else if (latch_set) begin
      latch_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_en_q <= 1'b0;
      lvl_q     <= LVL_OPEN;
      latch_q   <= 1'b0;
      job_q     <= JOB_STATUS;
    end else begin
      prot_en_q <= prot_en_d;
      lvl_q     <= lvl_d;
      latch_q   <= latch_d;
      job_q     <= job_d;
    end
  end

  // Sector capture, loaded only on an accepted program.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      buf_q  <= '0;
    end else if (start_array) begin
      base_q <= pg_addr[ADDR_W-1:OFS_W];
      buf_q  <= pg_data;
    end
  end

  for (genvar k = 0; k < SECTOR_BYTES; k++) begin : g_bytes
    assign sector_byte[k] = buf_q[8*k +: 8];
  end

  assign busy      = cyc_busy;
  assign mem_we    = idx_valid & (job_q == JOB_ARRAY);
  assign mem_addr  = {base_q, idx};
  assign mem_wdata = sector_byte[idx];
  assign status    = cyc_busy ? 8'hFF
                              : {prot_en_q, 3'b000, lvl_q, latch_q, 1'b0};
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prot_pin,
  input logic              pg_req,
  input logic [7:0]        status,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  assert_busy_reads_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status == 8'hFF);

  assert_strobe_inside_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_strobe_addr_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  assert_latch_cleared_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !status[1]);

  assert_start_needs_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(status[1]));

  assert_no_status_write_under_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(!pg_req)) |-> !$past(status[7] && !prot_pin));

  assert_full_lock_blocks_array_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(pg_req)) |-> $past(status[3:2]) != 2'b11);
endmodule

bind flash_guard fg_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .prot_pin (prot_pin),
  .pg_req   (pg_req),
  .status   (status),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_addr (mem_addr)
);

// File: tb/flash_guard_tb.sv
`timescale 1ns/1ps
module flash_guard_tb;
  localparam int ADDR_W = 14;
  localparam int SB     = 32;
  localparam int PC     = 40;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              prot_pin = 1'b1;
  logic              latch_set = 1'b0, latch_clr = 1'b0;
  logic              sr_seq = 1'b0, sr_req = 1'b0;
  logic [7:0]        sr_data = '0;
  logic              pg_req = 1'b0;
  logic [ADDR_W-1:0] pg_addr = '0;
  logic [SB*8-1:0]   pg_data = '0;
  logic [7:0]        status;
  logic              busy, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_guard #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SB), .PROG_CYCLES(PC)) u_dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model.
  int          m_left = 0, m_widx = 0;
  bit          m_ppen = 0, m_pel = 0, m_arr = 0, m_cancel = 0, m_seq = 0;
  bit [1:0]    m_bl = 0;
  logic [ADDR_W-1:0] m_base = '0;
  logic [SB*8-1:0]   m_buf = '0;

  function automatic bit m_locked(input logic [ADDR_W-1:0] a);
    case (m_bl)
      2'b00: return 0;
      2'b01: return a >= ADDR_W'(3 * (1 << (ADDR_W - 2)));
      2'b10: return a >= ADDR_W'(1 << (ADDR_W - 1));
      default: return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left = 0; m_widx = 0; m_ppen = 0; m_pel = 0; m_arr = 0;
      m_cancel = 0; m_seq = 0; m_bl = 0;
    end else begin
      bit hwp, old_cancel;
      hwp = m_ppen && !prot_pin;
      old_cancel = m_cancel;
      if (m_left > 0) begin
        m_left--;
        if (m_widx < SB) m_widx++;
        if (m_left == 0) m_pel = 0;
      end else begin
        if (pg_req && m_pel && !m_locked(pg_addr)) begin
          m_left = PC; m_widx = 0; m_arr = 1;
          m_base = pg_addr & ~ADDR_W'(SB - 1);
          m_buf = pg_data;
        end else if (!pg_req && sr_req && m_pel && !hwp && !old_cancel) begin
          m_left = PC; m_widx = 0; m_arr = 0;
          m_ppen = sr_data[7]; m_bl = sr_data[3:2];
        end
        if (latch_clr) m_pel = 0;
        else if (latch_set) m_pel = 1;
      end
      if (sr_seq) m_cancel = m_seq ? (old_cancel | hwp) : hwp;
      else if (sr_req) m_cancel = 0;
      m_seq = sr_seq;
    end
  end

  // Cycle-by-cycle comparison.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      logic [7:0] exp_st;
      bit exp_we;
      exp_st = (m_left > 0) ? 8'hFF : {m_ppen, 3'b000, m_bl, m_pel, 1'b0};
      exp_we = (m_left > 0) && m_arr && (m_widx < SB);
      check(status == exp_st, "R1/R2 status byte", status, exp_st);
      check(busy == (m_left > 0), "R2 busy flag", busy, m_left > 0);
      check(mem_we == exp_we, "R9 write strobe", mem_we, exp_we);
      if (exp_we) begin
        logic [ADDR_W-1:0] ea;
        ea = m_base | ADDR_W'(m_widx);
        check(mem_addr == ea, "R9 write address", mem_addr, ea);
        check(mem_wdata == m_buf[8*m_widx +: 8], "R9 write data", mem_wdata, m_buf[8*m_widx +: 8]);
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      summary();
    end
  end

  task automatic pulse_latch(input bit s, input bit c);
    @(negedge clk); latch_set = s; latch_clr = c;
    @(negedge clk); latch_set = 0; latch_clr = 0;
  endtask

  task automatic prog(input logic [ADDR_W-1:0] a, input logic [7:0] seed);
    @(negedge clk);
    pg_addr = a;
    for (int k = 0; k < SB; k++) pg_data[8*k +: 8] = seed + 8'(k * 7);
    pg_req = 1;
    @(negedge clk); pg_req = 0;
  endtask

  task automatic swr(input logic [7:0] d, input bit glitch);
    @(negedge clk); sr_seq = 1;
    for (int i = 0; i < 8; i++) begin
      if (glitch && i == 2) prot_pin = 0;
      if (glitch && i == 4) prot_pin = 1;
      @(negedge clk);
    end
    sr_seq = 0; sr_req = 1; sr_data = d;
    @(negedge clk); sr_req = 0;
  endtask

  task automatic run_busy(output int nb, output int nw, input bit disturb);
    nb = 0; nw = 0;
    while (busy) begin
      if (mem_we) nw++;
      nb++;
      if (disturb && nb == 5) begin prot_pin = 0; latch_set = 1; pg_req = 1; pg_addr = '0; end
      if (disturb && nb == 6) begin latch_set = 0; pg_req = 0; end
      @(negedge clk);
    end
    if (disturb) prot_pin = 1;
  endtask

  initial begin
    int nb, nw;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(status == 8'h00 && !busy && !mem_we, "R1 reset state", status, 8'h00);

    prog(14'h0100, 8'h11);
    check(!busy, "R4 program without latch", busy, 0);
    swr(8'h8C, 0);
    check(!busy && status == 8'h00, "R4 status write without latch", status, 8'h00);

    pulse_latch(1, 0);
    check(status == 8'h02, "R3 latch set", status, 8'h02);
    pulse_latch(1, 1);
    check(status == 8'h00, "R3 clear wins over set", status, 8'h00);
    pulse_latch(1, 0);

    swr(8'hFF, 0);
    check(busy && status == 8'hFF, "R2 busy reads all ones", status, 8'hFF);
    run_busy(nb, nw, 0);
    check(nb == PC, "R9 status cycle length", nb, PC);
    check(nw == 0, "R9 no strobe on status write", nw, 0);
    check(status == 8'h8C, "R5 R10 stored fields, latch cleared", status, 8'h8C);

    prot_pin = 0;
    pulse_latch(1, 0);
    swr(8'h00, 0);
    check(!busy && status == 8'h8E, "R6 protected status write refused", status, 8'h8E);
    prot_pin = 1;
    swr(8'h00, 0);
    run_busy(nb, nw, 0);
    check(status == 8'h00, "R6 pin high allows write", status, 8'h00);

    prot_pin = 0;
    pulse_latch(1, 0);
    swr(8'h84, 0);
    run_busy(nb, nw, 0);
    check(status == 8'h84, "R6 pin ignored when protect-enable 0", status, 8'h84);
    pulse_latch(1, 0);
    swr(8'h00, 0);
    check(!busy && status == 8'h86, "R6 protect-enable guards itself", status, 8'h86);
    prot_pin = 1;

    swr(8'h00, 1);
    check(!busy && status == 8'h86, "R7 pin glitch cancels write", status, 8'h86);
    swr(8'h84, 0);
    run_busy(nb, nw, 0);
    check(status == 8'h84, "R7 clean sequence accepted", status, 8'h84);

    pulse_latch(1, 0);
    prog(14'h3000, 8'h21);
    check(!busy && status == 8'h86, "R8 quarter lock refuses, latch kept", status, 8'h86);
    prog(14'h2FE0, 8'h31);
    run_busy(nb, nw, 0);
    check(nb == PC && nw == SB, "R9 program length and strobe count", nb * 256 + nw, PC * 256 + SB);
    check(status == 8'h84, "R10 latch cleared after program", status, 8'h84);

    pulse_latch(1, 0);
    swr(8'h88, 0);
    run_busy(nb, nw, 0);
    pulse_latch(1, 0);
    prog(14'h2000, 8'h41);
    check(!busy, "R8 half lock refuses upper half", busy, 0);
    prog(14'h1FE5, 8'h51);
    run_busy(nb, nw, 0);
    check(nw == SB, "R8 half lock allows lower half", nw, SB);

    pulse_latch(1, 0);
    swr(8'h8C, 0);
    run_busy(nb, nw, 1);
    check(nb == PC && status == 8'h8C, "R11 disturbances during busy ignored", status, 8'h8C);
    @(negedge clk);
    check(!busy, "R11 request during busy not queued", busy, 0);
    pulse_latch(1, 0);
    prog(14'h0000, 8'h61);
    check(!busy && status == 8'h8E, "R8 full lock refuses all", status, 8'h8E);

    @(negedge clk); pg_req = 1; sr_req = 1; sr_data = 8'h00; pg_addr = 14'h0040;
    @(negedge clk); pg_req = 0; sr_req = 0;
    check(!busy && status == 8'h8E, "R12 status write with program request ignored", status, 8'h8E);

    swr(8'h00, 0);
    run_busy(nb, nw, 0);
    pulse_latch(1, 0);
    prog(14'h3FE7, 8'h71);
    run_busy(nb, nw, 0);
    check(nw == SB && status == 8'h00, "R8 open level allows top sector", nw, SB);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule